// File: doc/BRIEF.md
# Unified Write-Through Cache with Snoop Invalidation

This block is a unified instruction and data cache of 8 KB. It has 4 ways per set and 16-byte lines. It sits between a 32-bit core request port and a line-fill memory port.

- **Reads.** A read that hits returns the cached word. A read that misses fetches the whole line as four 32-bit beats and returns the requested word from that fill.
- **Writes.** Every write is sent on to memory. A write that hits also updates the cached bytes. A write that misses does not allocate a line.
- **Invalidation.** An external master can invalidate one line. It holds the address path (`snoop_hold`), strobes (`snoop_strobe`) and supplies a line address. A single `flush` pulse empties the whole cache.
- **Test controls.** Two configuration bits exist for testing. One stops allocation. The other stops memory writes on write hits.
- **Per-fill gating.** A cache-enable input sampled with every fill beat decides whether the line is kept.
- **Write policy hint.** The request's page write-through attribute is passed on with each memory request, so external logic can choose its own write policy.

The core request, core response and memory request ports are valid/ready channels. A request is accepted on a cycle where valid and ready are both high. Once a channel raises valid, it holds its payload steady until ready is seen. The block takes one request at a time, so `req_ready` stays low from acceptance until the response is taken. Fill beats, snoop, flush and the configuration bits are plain signals with no back-pressure.

Address bits [10:4] select one of 128 sets and bits [31:11] form the tag. Each set keeps a 3-bit binary-tree pseudo-LRU.

Top module: `wt_cache`

## Requirements
- R1: A read miss issues one memory read at the line-aligned address, takes four beats (beat i is the word at line base + 4*i), and responds with the beat whose index equals address bits [3:2].
- R2: A read of a line already present responds with its data and issues no memory request.
- R3: A write hit merges the enabled bytes (`req_be` bit b covers data bits [8b+7:8b]) into the cached word. It also issues one memory write carrying the request's address, data, byte enables and page write-through bit on `mem_req_pwt`.
- R4: A write miss issues a memory write and allocates nothing, so a later read of that line misses.
- R5: With `cfg_no_write_through` high, a write hit updates the cache and issues no memory write.
- R6: With `cfg_cache_disable` high, a read miss still returns data but the line is not kept, so each repeat read misses.
- R7: A filled line becomes valid only if `fill_cacheable` was high on all four of its beats; otherwise the read still returns the right word.
- R8: `snoop_strobe` together with `snoop_hold` invalidates the line whose address equals `snoop_line_addr` (address bits [31:4]). A strobe without hold does nothing, and other lines stay valid.
- R9: A snoop or flush that names the line being filled, arriving during that fill, keeps the fill from becoming valid.
- R10: A one-cycle `flush` pulse invalidates every line.
- R11: On a miss the victim is the lowest-numbered invalid way of the set. If all ways are valid, the victim is the way picked by the tree pseudo-LRU, which every hit and every kept fill points away from.
- R12: `rsp_valid` with `rsp_rdata`, and `mem_req_valid` with its payload, stay stable until accepted. `req_ready` is low while a request is in progress.
- R13: After reset the cache is empty, `req_ready` is high and neither `rsp_valid` nor `mem_req_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| req_pwt | input | 1 | Page write-through attribute of the request |
| rsp_valid | output | 1 | Response valid (read data or write completion) |
| rsp_ready | input | 1 | Core takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-through, 0 = line read |
| mem_req_addr | output | 32 | Memory address (line-aligned for reads) |
| mem_req_wdata | output | 32 | Write-through data |
| mem_req_be | output | 4 | Byte enables (all ones for reads) |
| mem_req_pwt | output | 1 | Page write-through attribute forwarded |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat data |
| fill_cacheable | input | 1 | Cache-enable qualifier for this beat |
| snoop_hold | input | 1 | External master holds the address path |
| snoop_strobe | input | 1 | External invalidate strobe |
| snoop_line_addr | input | 28 | Line address to invalidate |
| flush | input | 1 | Invalidate the whole cache |
| cfg_cache_disable | input | 1 | Suppress allocation |
| cfg_no_write_through | input | 1 | Suppress memory writes on write hits |

## Verification
The embedded assertions check several properties on every cycle:

- The response and memory request channels hold steady under back-pressure.
- At most one way hits.
- The cache is empty on the cycle after a flush.
- An invalid way is always chosen ahead of a valid one.
- A write never validates a line.
- A no-write-through write hit raises no memory request.
- A snoop that names the line being filled keeps that fill from becoming valid.

Only the directed scenarios can show the data-level outcomes. These include:

- correct merged bytes after a write hit;
- stale memory after a suppressed write;
- the exact pseudo-LRU victim after a chosen access order;
- lines surviving or vanishing after snoops, flushes and cache-enable gating.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int CACHE_BYTES = 8192;
  localparam int NUM_WAYS    = 4;
  localparam int LINE_BYTES  = 16;

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = LINE_BYTES / WORD_BYTES;
  localparam int SETS       = CACHE_BYTES / (NUM_WAYS * LINE_BYTES);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int WSEL_W     = $clog2(WORDS);
  localparam int WAY_W      = $clog2(NUM_WAYS);
  localparam int LINE_W     = ADDR_W - OFF_W;
  localparam int DIDX_W     = IDX_W + WAY_W + WSEL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_FREQ, ST_FILL, ST_WREQ, ST_RESP
  } cstate_e;
endpackage

// File: rtl/wtc_tags.sv
`timescale 1ns/1ps
module wtc_tags import wtc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [IDX_W-1:0]    lk_set_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic                lk_hit_o,
  output logic [WAY_W-1:0]    lk_way_o,
  output logic [NUM_WAYS-1:0] lk_valid_o,
  input  logic                sn_en_i,
  input  logic [IDX_W-1:0]    sn_set_i,
  input  logic [TAG_W-1:0]    sn_tag_i,
  input  logic                al_en_i,
  input  logic [IDX_W-1:0]    al_set_i,
  input  logic [WAY_W-1:0]    al_way_i,
  input  logic [TAG_W-1:0]    al_tag_i,
  input  logic                sv_en_i,
  input  logic [IDX_W-1:0]    sv_set_i,
  input  logic [WAY_W-1:0]    sv_way_i
);
  logic [TAG_W-1:0]    tag_q [SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] vld_q [SETS];
  logic [NUM_WAYS-1:0] hit_vec;
  logic                any_valid;

  always_ff @(posedge clk) begin
    if (al_en_i) tag_q[al_set_i][al_way_i] <= al_tag_i;
  end

  // Later assignments win: snoop and allocation clears override a set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      if (sv_en_i) vld_q[sv_set_i][sv_way_i] <= 1'b1;
      if (al_en_i) vld_q[al_set_i][al_way_i] <= 1'b0;
      if (sn_en_i) begin
        for (int w = 0; w < NUM_WAYS; w++)
          if (tag_q[sn_set_i][w] == sn_tag_i) vld_q[sn_set_i][w] <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hit_vec[w] = vld_q[lk_set_i][w] && (tag_q[lk_set_i][w] == lk_tag_i);
      if (hit_vec[w]) lk_way_o = WAY_W'(w);
    end
    lk_hit_o   = |hit_vec;
    lk_valid_o = vld_q[lk_set_i];
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
  end

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !any_valid);
endmodule

// File: rtl/wtc_plru.sv
`timescale 1ns/1ps
module wtc_plru import wtc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [IDX_W-1:0]    set_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  output logic [WAY_W-1:0]    victim_o,
  input  logic                touch_en_i,
  input  logic [IDX_W-1:0]    touch_set_i,
  input  logic [WAY_W-1:0]    touch_way_i
);
  localparam int NODES = NUM_WAYS - 1;
  // Node 0 picks the half, node 1 the lower pair, node 2 the upper pair.
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en_i) begin
      tree_q[touch_set_i][0] <= ~touch_way_i[1];
      if (touch_way_i[1]) tree_q[touch_set_i][2] <= ~touch_way_i[0];
      else                tree_q[touch_set_i][1] <= ~touch_way_i[0];
    end
  end

  always_comb begin
    cur = tree_q[set_i];
    victim_o = {cur[0], cur[0] ? cur[2] : cur[1]};
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end

  a_r11_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i != '1) |-> !valid_i[victim_o]);
endmodule

// File: rtl/wtc_data.sv
`timescale 1ns/1ps
module wtc_data import wtc_pkg::*; (
  input  logic                  clk,
  input  logic [DIDX_W-1:0]     rd_idx_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  we_i,
  input  logic [DIDX_W-1:0]     wr_idx_i,
  input  logic [WORD_BYTES-1:0] wr_be_i,
  input  logic [DATA_W-1:0]     wr_data_i
);
  localparam int DEPTH = SETS * NUM_WAYS * WORDS;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < WORD_BYTES; b++)
        if (wr_be_i[b]) mem_q[wr_idx_i][8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache import wtc_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [WORD_BYTES-1:0] req_be,
  input  logic                  req_pwt,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [DATA_W-1:0]     mem_req_wdata,
  output logic [WORD_BYTES-1:0] mem_req_be,
  output logic                  mem_req_pwt,
  input  logic                  fill_valid,
  input  logic [DATA_W-1:0]     fill_data,
  input  logic                  fill_cacheable,
  input  logic                  snoop_hold,
  input  logic                  snoop_strobe,
  input  logic [LINE_W-1:0]     snoop_line_addr,
  input  logic                  flush,
  input  logic                  cfg_cache_disable,
  input  logic                  cfg_no_write_through
);
  cstate_e st_q;
  logic [ADDR_W-1:0]     a_q;
  logic [DATA_W-1:0]     wd_q, rdata_q;
  logic [WORD_BYTES-1:0] be_q;
  logic                  wr_q, pwt_q, keep_q, keep_d;
  logic [WAY_W-1:0]      way_q, hit_way, victim;
  logic [WSEL_W-1:0]     beat_q;
  logic [NUM_WAYS-1:0]   set_valid;
  logic                  hit, snp_fire, snp_line, look_hit, sv_en, al_en, last_beat;
  logic [IDX_W-1:0]      set_idx;
  logic [TAG_W-1:0]      ltag;
  logic [WSEL_W-1:0]     wsel;
  logic                  dwe;
  logic [DIDX_W-1:0]     dwidx;
  logic [WORD_BYTES-1:0] dwbe;
  logic [DATA_W-1:0]     dwdata, drdata;

  assign set_idx  = a_q[OFF_W +: IDX_W];
  assign ltag     = a_q[ADDR_W-1 -: TAG_W];
  assign wsel     = a_q[BSEL_W +: WSEL_W];
  assign snp_fire = snoop_hold & snoop_strobe;
  assign snp_line = snp_fire && (snoop_line_addr == a_q[ADDR_W-1:OFF_W]);
  assign look_hit = (st_q == ST_LOOK) && hit;
  assign last_beat = (beat_q == WSEL_W'(WORDS - 1));

  // Whether the line under fill may still become valid.
  always_comb begin
    keep_d = keep_q;
    if (st_q == ST_FREQ) keep_d = !cfg_cache_disable;
    if (st_q == ST_FILL && fill_valid) keep_d = keep_d & fill_cacheable;
    if (snp_line || flush) keep_d = 1'b0;
  end

  assign al_en = (st_q == ST_FREQ) && mem_req_ready && !cfg_cache_disable;
  assign sv_en = (st_q == ST_FILL) && fill_valid && last_beat && keep_d;

  // Channel outputs
  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign mem_req_valid = (st_q == ST_FREQ) || (st_q == ST_WREQ);
  assign mem_req_write = (st_q == ST_WREQ);
  assign mem_req_addr  = (st_q == ST_WREQ) ? a_q : {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = wd_q;
  assign mem_req_be    = (st_q == ST_WREQ) ? be_q : '1;
  assign mem_req_pwt   = pwt_q;

  // Data array write: write hit merge or fill beat
  always_comb begin
    dwe    = 1'b0;
    dwidx  = {set_idx, hit_way, wsel};
    dwbe   = be_q;
    dwdata = wd_q;
    if (look_hit && wr_q) begin
      dwe = 1'b1;
    end else if (st_q == ST_FILL && fill_valid && keep_q) begin
      dwe    = 1'b1;
      dwidx  = {set_idx, way_q, beat_q};
      dwbe   = '1;
      dwdata = fill_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      pwt_q   <= 1'b0;
      rdata_q <= '0;
      way_q   <= '0;
      beat_q  <= '0;
      keep_q  <= 1'b0;
    end else begin
      keep_q <= keep_d;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          be_q  <= req_be;
          wr_q  <= req_write;
          pwt_q <= req_pwt;
          st_q  <= ST_LOOK;
        end
        ST_LOOK: begin
          way_q <= victim;
          if (wr_q) begin
            rdata_q <= '0;
            st_q    <= (hit && cfg_no_write_through) ? ST_RESP : ST_WREQ;
          end else if (hit) begin
            rdata_q <= drdata;
            st_q    <= ST_RESP;
          end else begin
            st_q    <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_req_ready) begin
          beat_q <= '0;
          st_q   <= ST_FILL;
        end
        ST_FILL: if (fill_valid) begin
          if (beat_q == wsel) rdata_q <= fill_data;
          beat_q <= beat_q + WSEL_W'(1);
          if (last_beat) st_q <= ST_RESP;
        end
        ST_WREQ: if (mem_req_ready) st_q <= ST_RESP;
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  wtc_tags u_tags (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .lk_set_i(set_idx), .lk_tag_i(ltag), .lk_hit_o(hit), .lk_way_o(hit_way),
    .lk_valid_o(set_valid),
    .sn_en_i(snp_fire), .sn_set_i(snoop_line_addr[IDX_W-1:0]),
    .sn_tag_i(snoop_line_addr[LINE_W-1:IDX_W]),
    .al_en_i(al_en), .al_set_i(set_idx), .al_way_i(way_q), .al_tag_i(ltag),
    .sv_en_i(sv_en), .sv_set_i(set_idx), .sv_way_i(way_q)
  );

  wtc_plru u_plru (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .set_i(set_idx), .valid_i(set_valid), .victim_o(victim),
    .touch_en_i(look_hit || sv_en), .touch_set_i(set_idx),
    .touch_way_i(look_hit ? hit_way : way_q)
  );

  wtc_data u_data (
    .clk(clk), .rd_idx_i({set_idx, hit_way, wsel}), .rd_data_o(drdata),
    .we_i(dwe), .wr_idx_i(dwidx), .wr_be_i(dwbe), .wr_data_i(dwdata)
  );

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);
  a_r4_write_never_validates: assert property (@(posedge clk) disable iff (!rst_n)
    sv_en |-> !wr_q);
  a_r5_no_wt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && wr_q && cfg_no_write_through) |=> !mem_req_valid);
  a_r9_snoop_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && snp_line) |=> !sv_en);
endmodule

// File: tb/wt_cache_tb.sv
`timescale 1ns/1ps
module wt_cache_tb;
  localparam int FILL_LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_pwt = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_ready = 1'b1, mem_req_write, mem_req_pwt;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic fill_valid = 0, fill_cacheable = 0;
  logic [31:0] fill_data = 0;
  logic snoop_hold = 0, snoop_strobe = 0, flush = 0;
  logic [27:0] snoop_line_addr = 0;
  logic cfg_cache_disable = 0, cfg_no_write_through = 0;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] lr_addr, lw_addr, lw_data;
  logic [3:0]  lw_be, cen_mask = 4'hF;
  logic        lw_pwt;
  logic [31:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  wt_cache u_dut (.*);

  function automatic logic [31:0] rdm(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        if (mem_req_write) begin
          logic [31:0] w;
          wr_cnt++;
          lw_addr = mem_req_addr; lw_data = mem_req_wdata;
          lw_be = mem_req_be; lw_pwt = mem_req_pwt;
          w = rdm(mem_req_addr);
          for (int b = 0; b < 4; b++) if (mem_req_be[b]) w[8*b +: 8] = mem_req_wdata[8*b +: 8];
          mem[mem_req_addr] = w;
        end else begin
          rd_cnt++;
          lr_addr = mem_req_addr;
          repeat (FILL_LAT) @(negedge clk);
          for (int i = 0; i < 4; i++) begin
            fill_valid = 1'b1;
            fill_data = rdm(lr_addr + 32'(4*i));
            fill_cacheable = cen_mask[i];
            @(negedge clk);
          end
          fill_valid = 1'b0;
        end
      end
    end
  end

  task automatic do_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_pwt = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic pwt);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be; req_pwt = pwt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic do_snoop(input logic [31:0] a, input logic hold);
    @(negedge clk);
    snoop_line_addr = a[31:4]; snoop_hold = hold; snoop_strobe = 1;
    @(negedge clk);
    snoop_hold = 0; snoop_strobe = 0;
  endtask

  task automatic t_reset();
    chk("R13 req_ready", 32'(req_ready), 1);
    chk("R13 rsp_valid", 32'(rsp_valid), 0);
    chk("R13 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] d; int r0;
    r0 = rd_cnt;
    do_read(32'h0000_0108, d);
    chk("R1 miss data", d, rdm(32'h108));
    chk("R1 one line read", 32'(rd_cnt - r0), 1);
    chk("R1 aligned addr", lr_addr, 32'h100);
    do_read(32'h0000_0104, d);
    chk("R2 hit data", d, rdm(32'h104));
    chk("R2 no bus read", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_write_hit();
    logic [31:0] d, exp; int w0, r0;
    exp = {rdm(32'h104)[31:16], 16'hBEEF};
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(32'h104, 32'hDEAD_BEEF, 4'b0011, 1'b1);
    chk("R3 write through", 32'(wr_cnt - w0), 1);
    chk("R3 wr addr", lw_addr, 32'h104);
    chk("R3 wr data", lw_data, 32'hDEAD_BEEF);
    chk("R3 wr be", 32'(lw_be), 32'h3);
    chk("R3 pwt forwarded", 32'(lw_pwt), 1);
    do_read(32'h104, d);
    chk("R3 merged bytes", d, exp);
    chk("R3 read hit", 32'(rd_cnt - r0), 0);
  endtask

  task automatic t_write_miss();
    logic [31:0] d; int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(32'h300, 32'h1234_5678, 4'hF, 1'b0);
    chk("R4 write sent", 32'(wr_cnt - w0), 1);
    do_read(32'h300, d);
    chk("R4 no allocate", 32'(rd_cnt - r0), 1);
    chk("R4 data", d, 32'h1234_5678);
  endtask

  task automatic t_no_wt();
    logic [31:0] d; int w0, r0;
    do_read(32'h400, d);
    cfg_no_write_through = 1;
    w0 = wr_cnt; r0 = rd_cnt;
    do_write(32'h400, 32'hCAFE_F00D, 4'hF, 1'b0);
    chk("R5 no mem write", 32'(wr_cnt - w0), 0);
    do_read(32'h400, d);
    chk("R5 cache updated", d, 32'hCAFE_F00D);
    chk("R5 hit", 32'(rd_cnt - r0), 0);
    cfg_no_write_through = 0;
    do_flush();
    do_read(32'h400, d);
    chk("R5 memory stale", d, 32'h400 ^ 32'hC3C3_0000);
  endtask

  task automatic t_disable();
    logic [31:0] d; int r0;
    cfg_cache_disable = 1;
    r0 = rd_cnt;
    do_read(32'h500, d);
    chk("R6 data", d, rdm(32'h500));
    do_read(32'h500, d);
    chk("R6 no allocate", 32'(rd_cnt - r0), 2);
    cfg_cache_disable = 0;
  endtask

  task automatic t_cen();
    logic [31:0] d; int r0;
    cen_mask = 4'b1011;
    r0 = rd_cnt;
    do_read(32'h60C, d);
    chk("R7 data ok", d, rdm(32'h60C));
    cen_mask = 4'hF;
    do_read(32'h60C, d);
    chk("R7 not kept", 32'(rd_cnt - r0), 2);
    do_read(32'h60C, d);
    chk("R7 kept when all beats", 32'(rd_cnt - r0), 2);
  endtask

  task automatic t_snoop();
    logic [31:0] d; int r0;
    do_read(32'h700, d);
    do_read(32'h800, d);
    r0 = rd_cnt;
    do_snoop(32'h700, 1'b0);
    do_read(32'h700, d);
    chk("R8 strobe without hold ignored", 32'(rd_cnt - r0), 0);
    do_snoop(32'h700, 1'b1);
    do_read(32'h700, d);
    chk("R8 snooped line misses", 32'(rd_cnt - r0), 1);
    do_read(32'h800, d);
    chk("R8 other line kept", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_snoop_fill();
    logic [31:0] d; int r0;
    r0 = rd_cnt;
    fork
      do_read(32'h904, d);
      begin
        @(negedge clk);
        while (!(mem_req_valid && !mem_req_write)) @(negedge clk);
        @(negedge clk);
        snoop_line_addr = 28'h000_0090; snoop_hold = 1; snoop_strobe = 1;
        @(negedge clk);
        snoop_hold = 0; snoop_strobe = 0;
      end
    join
    chk("R9 data returned", d, rdm(32'h904));
    do_read(32'h904, d);
    chk("R9 fill not kept", 32'(rd_cnt - r0), 2);
  endtask

  task automatic t_flush();
    logic [31:0] d; int r0;
    do_read(32'hA00, d);
    do_read(32'hB00, d);
    do_flush();
    r0 = rd_cnt;
    do_read(32'hA00, d);
    do_read(32'hB00, d);
    chk("R10 all lines gone", 32'(rd_cnt - r0), 2);
  endtask

  task automatic t_plru();
    logic [31:0] d; int r0;
    do_flush();
    do_read(32'h0050, d); // A -> way0
    do_read(32'h0850, d); // B -> way1
    do_read(32'h1050, d); // C -> way2
    do_read(32'h1850, d); // D -> way3
    do_read(32'h0050, d); // hit A, tree now points at way2
    do_read(32'h2050, d); // E evicts C
    r0 = rd_cnt;
    do_read(32'h0050, d);
    do_read(32'h0850, d);
    do_read(32'h1850, d);
    chk("R11 A B D survive", 32'(rd_cnt - r0), 0);
    do_read(32'h1050, d);
    chk("R11 C was victim", 32'(rd_cnt - r0), 1);
  endtask

  task automatic t_backpressure();
    logic [31:0] d0;
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 32'h0850;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_rdata;
    chk("R12 data", d0, rdm(32'h850));
    repeat (3) begin
      @(negedge clk);
      chk("R12 valid held", 32'(rsp_valid), 1);
      chk("R12 data held", rsp_rdata, d0);
      chk("R12 busy", 32'(req_ready), 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R12 released", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_write_hit();
    t_write_miss();
    t_no_wt();
    t_disable();
    t_cen();
    t_snoop();
    t_snoop_fill();
    t_flush();
    t_plru();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule